// File: doc/BRIEF.md
# Serial EEPROM Slave (2048 x 8, SPI)

This block behaves like a 2048-byte serial EEPROM placed behind an SPI bus. It works in clock polarity/phase mode 0 or mode 3. Chip select, serial clock and data-in are brought into the system clock domain through synchronisers and edge detectors. Inputs are sampled on serial-clock rising edges, and the output bit changes after each falling edge. Every transfer is most significant bit first.

Each transfer starts with a one-byte command. The array commands then take a 16-bit address, of which only the low 11 bits are used.

- **Reads** stream bytes with an address that counts up on every byte.
- **Writes** gather up to 32 bytes in a page buffer. When chip select rises cleanly, the buffer is committed during a self-timed busy period.

Status and protection come from outside the block:

- A neighbouring protection block supplies the six upper status bits.
- It also supplies a lock flag for the status register and a lock flag for the page on `wrPage`.
- A committed status write is handed back to it as a one-cycle strobe.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Command codes are 0x06 set write latch, 0x04 clear write latch, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. Any other code leaves `sdoOe` low and is ignored until chip select goes high. `sdoOe` is never high while chip select has been high for more than a few clocks.
- R2: After reset no command runs until a falling edge of `csN` has been seen. Bits clocked while `csN` was already low through reset give no output.
- R3: Input bits are taken on a rising `sclk` edge and output bits change after a falling edge, MSB first. Mode 0 (idle low) and mode 3 (idle high) both work.
- R4: The array commands take a 16-bit address whose upper 5 bits are ignored.
- R5: A read returns the addressed byte and then the following bytes for as long as `csN` stays low. The address wraps from 0x7FF to 0x000.
- R6: A read command issued while busy is rejected (`sdoOe` stays low).
- R7: Data bytes of a write advance only address bits 4:0. A write longer than 32 bytes wraps to the page start and overwrites the earlier bytes.
- R8: A write commits only if `csN` rises after a whole number of data bytes, with at least one data byte sent. Otherwise nothing is written and busy stays 0.
- R9: A write is refused if the write latch is clear, if a busy cycle is running, or if `pageLocked` is high for the addressed page.
- R10: A committed write holds busy for WR_CYCLES system clocks. At the end, busy returns to 0 and the write latch is cleared.
- R11: The status byte is {protBits[5:0], latch, busy} with busy in bit 0 and the latch in bit 1. It can be read while busy, and it repeats for as long as `csN` stays low.
- R12: A status write needs the latch set, `stLocked` low and no busy cycle. It commits only if `csN` rises right after the data byte. On commit, `stWrStb` pulses once with the byte on `stWrByte`, and a busy cycle starts.
- R13: Command 0x06 sets the write latch and 0x04 clears it; the latch is visible in status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Drive enable for sdo |
| protBits | input | 6 | Status bits 7:2 from the protection block |
| stLocked | input | 1 | Status register write is locked |
| wrPage | output | 6 | Page index of the current address |
| pageLocked | input | 1 | The page on wrPage is protected |
| stWrStb | output | 1 | One-cycle pulse: status write committed |
| stWrByte | output | 8 | Byte of the committed status write |

## Verification
The assertions rely on two assumptions about the bus. The serial clock must be slow against the system clock: each `sclk` half period lasts several system clocks beyond the synchroniser delay, so no edge is lost or merged. `sdi` and `csN` must stay stable for several clocks around each `sclk` edge. The stimulus meets both by driving every bus signal on falling system-clock edges, holding each `sclk` phase for eight system clocks, and keeping `csN` high for sixteen clocks between transfers. `pageLocked` is computed combinationally from `wrPage`, as a real protection block would do.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_RARR  = 8'h03;
  localparam logic [7:0] OP_WARR  = 8'h02;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;
    logic shiftOut;
    logic addrHiLd;
    logic addrLoLd;
    logic txFromMem;
    logic rdNext;
    logic txFromStat;
    logic bufClr;
    logic bufWr;
    logic lastLd;
    logic commitWr;
    logic commitStat;
  } eepStrobes_t;
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic [7:0]  rxByte,
  input  logic        busy,
  input  logic        busyDone,
  input  logic        pageLocked,
  input  logic        stLocked,
  output logic        sdiS,
  output logic        wel,
  output logic        sdoOe,
  output eepStrobes_t stb
);
  typedef enum logic [3:0] {IDLE, OPC, ADR1, ADR2, PEND, RDAT, STAT, WDAT, WST, WSTE, SKIP} state_t;
  state_t state;

  logic [SYNC_STAGES-1:0] csPipe, sckPipe, sdiPipe;
  logic csPrev, sckPrev;
  logic csS, sckS, csRise, csFall, sckRise, sckFall, byteDone;
  logic [2:0] bitCnt;
  logic isWrite, gotByte;

  // pipes reset low: chip select held low through reset gives no falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csPipe <= '0; sckPipe <= '0; sdiPipe <= '0;
      csPrev <= 1'b0; sckPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  assign csS     = csPipe[SYNC_STAGES-1];
  assign sckS    = sckPipe[SYNC_STAGES-1];
  assign sdiS    = sdiPipe[SYNC_STAGES-1];
  assign csRise  = csS & ~csPrev;
  assign csFall  = ~csS & csPrev;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign byteDone = sckRise && (bitCnt == 3'd7) && (state != IDLE) && (state != SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; bitCnt <= '0; isWrite <= 1'b0; gotByte <= 1'b0; wel <= 1'b0;
    end else begin
      if (busyDone) wel <= 1'b0;
      if (csRise) state <= IDLE;
      else if (csFall) begin
        state <= OPC; bitCnt <= '0; gotByte <= 1'b0;
      end else begin
        if (state == PEND) state <= isWrite ? (pageLocked ? SKIP : WDAT) : RDAT;
        if (sckRise && state != IDLE) begin
          bitCnt <= bitCnt + 3'd1;
          if (state == WSTE) state <= SKIP;
          if (bitCnt == 3'd7) begin
            unique case (state)
              OPC: begin
                state <= SKIP;
                case (rxByte)
                  OP_WEN:   wel <= 1'b1;
                  OP_WDIS:  wel <= 1'b0;
                  OP_RSTAT: state <= STAT;
                  OP_WSTAT: if (wel && !busy && !stLocked) state <= WST;
                  OP_RARR:  if (!busy) begin state <= ADR1; isWrite <= 1'b0; end
                  OP_WARR:  if (wel && !busy) begin state <= ADR1; isWrite <= 1'b1; end
                  default:  state <= SKIP;
                endcase
              end
              ADR1: state <= ADR2;
              ADR2: state <= PEND;
              WDAT: gotByte <= 1'b1;
              WST:  state <= WSTE;
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    stb = '0;
    stb.sampleBit  = sckRise && state != IDLE && state != SKIP;
    stb.shiftOut   = sckFall && (state == RDAT || state == STAT);
    stb.addrHiLd   = byteDone && state == ADR1;
    stb.addrLoLd   = byteDone && state == ADR2;
    stb.txFromMem  = state == PEND && !isWrite;
    stb.rdNext     = byteDone && state == RDAT;
    stb.txFromStat = byteDone && ((state == OPC && rxByte == OP_RSTAT) || state == STAT);
    stb.bufClr     = byteDone && state == OPC;
    stb.bufWr      = byteDone && state == WDAT;
    stb.lastLd     = byteDone && state == WST;
    stb.commitWr   = csRise && state == WDAT && bitCnt == 3'd0 && gotByte;
    stb.commitStat = csRise && state == WSTE && bitCnt == 3'd0;
  end

  assign sdoOe = (state == RDAT) || (state == STAT);

  // R9
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commitWr |-> (wel && !busy));
  // R6
  rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PEND && !isWrite) |-> !busy);
  // R10
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyDone |=> !wel);
  // R1
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdoOe && csS) |=> !sdoOe);
endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  eepStrobes_t              stb,
  input  logic                     sdiS,
  input  logic                     wel,
  input  logic [5:0]               protBits,
  output logic [7:0]               rxByte,
  output logic                     sdo,
  output logic                     busy,
  output logic                     busyDone,
  output logic [ADDR_W-PAGE_W-1:0] wrPage,
  output logic                     stWrStb,
  output logic [7:0]               stWrByte
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int CNT_W      = $clog2(WR_CYCLES);

  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [6:0] rxSh;
  logic [7:0] tx, lastByte, statusByte;
  logic [HI_W-1:0] addrHi;
  logic [ADDR_W-1:0] addr, addrInc;
  logic [ADDR_W-PAGE_W-1:0] commitPage;
  logic [CNT_W-1:0] busyCnt;
  logic wrArray, memWe;
  logic [PAGE_W-1:0] slot;

  assign rxByte     = {rxSh, sdiS};
  assign statusByte = {protBits, wel, busy};
  assign addrInc    = addr + 1'b1;
  assign wrPage     = addr[ADDR_W-1:PAGE_W];
  assign slot       = busyCnt[PAGE_W-1:0];
  assign memWe      = busy && wrArray && (busyCnt < CNT_W'(PAGE_BYTES)) && pageVld[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh <= '0; tx <= '0; sdo <= 1'b0; addrHi <= '0; addr <= '0; lastByte <= '0;
      pageVld <= '0; busy <= 1'b0; busyDone <= 1'b0; busyCnt <= '0; wrArray <= 1'b0;
      commitPage <= '0; stWrStb <= 1'b0; stWrByte <= '0;
    end else begin
      busyDone <= 1'b0;
      stWrStb  <= 1'b0;
      if (stb.sampleBit) rxSh <= rxByte[6:0];
      if (stb.addrHiLd)  addrHi <= rxByte[HI_W-1:0];
      if (stb.addrLoLd)  addr <= {addrHi, rxByte};
      if (stb.rdNext)    addr <= addrInc;
      if (stb.bufWr)     addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
      if (stb.lastLd)    lastByte <= rxByte;
      if (stb.shiftOut) begin
        sdo <= tx[7];
        tx  <= {tx[6:0], 1'b0};
      end
      if (stb.txFromMem)  tx <= mem[addr];
      if (stb.rdNext)     tx <= mem[addrInc];
      if (stb.txFromStat) tx <= statusByte;
      if (stb.bufClr) pageVld <= '0;
      if (stb.bufWr)  pageVld[addr[PAGE_W-1:0]] <= 1'b1;
      if (stb.commitWr || stb.commitStat) begin
        busy <= 1'b1; busyCnt <= '0; wrArray <= stb.commitWr;
        commitPage <= addr[ADDR_W-1:PAGE_W];
      end else if (busy) begin
        busyCnt <= busyCnt + 1'b1;
        if (busyCnt == CNT_W'(WR_CYCLES - 1)) begin
          busy <= 1'b0; busyDone <= 1'b1;
        end
      end
      if (stb.commitStat) begin
        stWrStb <= 1'b1; stWrByte <= lastByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) pageBuf[addr[PAGE_W-1:0]] <= rxByte;
    if (memWe) mem[{commitPage, slot}] <= pageBuf[slot];
  end

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stb.commitWr || stb.commitStat));
  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.bufWr |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdNext |=> (addr == ADDR_W'($past(addr) + 1'b1)));
  // R12
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stWrStb |-> busy);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     sdoOe,
  input  logic [5:0]               protBits,
  input  logic                     stLocked,
  output logic [ADDR_W-PAGE_W-1:0] wrPage,
  input  logic                     pageLocked,
  output logic                     stWrStb,
  output logic [7:0]               stWrByte
);
  eepStrobes_t stb;
  logic [7:0] rxByte;
  logic sdiS, wel, busy, busyDone;

  eep_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdi(sdi),
    .rxByte(rxByte), .busy(busy), .busyDone(busyDone),
    .pageLocked(pageLocked), .stLocked(stLocked),
    .sdiS(sdiS), .wel(wel), .sdoOe(sdoOe), .stb(stb)
  );

  eep_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdiS(sdiS), .wel(wel), .protBits(protBits),
    .rxByte(rxByte), .sdo(sdo), .busy(busy), .busyDone(busyDone), .wrPage(wrPage),
    .stWrStb(stWrStb), .stWrByte(stWrByte)
  );
endmodule

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
  localparam int H  = 8;
  localparam int WR = 900;

  logic clk = 1'b0, rst_n = 1'b0, csN = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoOe, stWrStb, pageLocked;
  logic [5:0] protBits = 6'b101101;
  logic stLocked = 1'b0;
  logic [5:0] wrPage;
  logic [7:0] stWrByte;
  logic lockEn = 1'b0;
  logic [5:0] lockPage = 6'h08;

  int nVec = 0, nBad = 0, stbCnt = 0, csHiCnt = 0;
  logic [7:0] stbByte = 8'h00;
  bit mode3 = 0, oeSeen = 0, done = 0;
  int refMem [2048];
  logic [7:0] wq[$];
  logic [7:0] rq[$];

  assign pageLocked = lockEn && (wrPage == lockPage);

  spi_eeprom_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe),
    .protBits(protBits), .stLocked(stLocked), .wrPage(wrPage), .pageLocked(pageLocked),
    .stWrStb(stWrStb), .stWrByte(stWrByte)
  );

  always #10 clk = ~clk;

  // every-clock comparison: no drive once chip select has settled high (R1)
  always @(negedge clk) begin
    if (sdoOe) oeSeen = 1;
    if (stWrStb) begin stbCnt++; stbByte = stWrByte; end
    if (csN) csHiCnt++; else csHiCnt = 0;
    if (rst_n && csHiCnt > 6) begin
      nVec++;
      if (sdoOe) begin nBad++; $display("FAIL R1 sdoOe act=1 exp=0 with csN high"); end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sclk = mode3; tick(2); oeSeen = 0; csN = 0; tick(H);
  endtask

  task automatic desel();
    tick(H); csN = 1; tick(2 * H);
  endtask

  task automatic shift(input logic [7:0] v, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < nb; i++) begin
      if (mode3) sclk = 0;
      sdi = v[7-i];
      tick(H);
      r[7-i] = sdo;
      sclk = 1;
      tick(H);
      if (!mode3) sclk = 0;
    end
  endtask

  task automatic op(input logic [7:0] o);
    logic [7:0] r;
    sel(); shift(o, 8, r); desel();
  endtask

  task automatic rdStat(input int n);
    logic [7:0] r;
    rq.delete();
    sel(); shift(8'h05, 8, r);
    for (int k = 0; k < n; k++) begin shift(8'h00, 8, r); rq.push_back(r); end
    desel();
  endtask

  task automatic rdArr(input logic [15:0] a, input int n);
    logic [7:0] r;
    rq.delete();
    sel(); shift(8'h03, 8, r); shift(a[15:8], 8, r); shift(a[7:0], 8, r);
    for (int k = 0; k < n; k++) begin shift(8'h00, 8, r); rq.push_back(r); end
    desel();
  endtask

  task automatic wrArr(input logic [15:0] a, input int extra);
    logic [7:0] r;
    sel(); shift(8'h02, 8, r); shift(a[15:8], 8, r); shift(a[7:0], 8, r);
    foreach (wq[k]) shift(wq[k], 8, r);
    if (extra > 0) shift(8'hA5, extra, r);
    desel();
  endtask

  task automatic modelWrite(input logic [15:0] a);
    foreach (wq[k]) refMem[{a[10:5], 5'(a[4:0] + k)}] = int'(wq[k]);
  endtask

  task automatic wrStat(input logic [7:0] v, input int extra);
    logic [7:0] r;
    sel(); shift(8'h01, 8, r); shift(v, 8, r);
    if (extra > 0) shift(8'h00, extra, r);
    desel();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=timeout exp=done");
    finishRun();
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 2048; i++) refMem[i] = -1;
    tick(5);
    check("R2 reset sdoOe", int'(sdoOe), 0);
    rst_n = 1; tick(5);
    // R2: chip select low since reset, no falling edge yet
    oeSeen = 0; shift(8'h05, 8, r); shift(8'h00, 8, r);
    check("R2 no command before cs fall", int'(oeSeen), 0);
    csN = 1; tick(2 * H);

    rdStat(1); check("R11 R3 status after reset", int'(rq[0]), 8'hB4);
    op(8'h06); rdStat(1); check("R13 latch set", int'(rq[0]), 8'hB6);
    op(8'h04); rdStat(1); check("R13 latch cleared", int'(rq[0]), 8'hB4);

    // R1 unknown command
    sel(); shift(8'hAB, 8, r); shift(8'h00, 8, r); desel();
    check("R1 unknown code no output", int'(oeSeen), 0);
    rdStat(1); check("R1 recovers after deselect", int'(rq[0]), 8'hB4);

    // write with upper address bits set (R4), then busy checks
    op(8'h06);
    wq = '{8'h11, 8'h22, 8'h33}; wrArr(16'hF905, 0); modelWrite(16'h0105);
    rdStat(2);
    check("R11 R10 busy status byte 1", int'(rq[0]), 8'hB7);
    check("R11 status repeats byte 2", int'(rq[1]), 8'hB7);
    rdArr(16'h0105, 1);
    check("R6 read rejected while busy", int'(oeSeen), 0);
    tick(WR + 100);
    rdStat(1); check("R10 idle and latch cleared", int'(rq[0]), 8'hB4);

    mode3 = 1;
    rdArr(16'h0105, 3);
    for (int k = 0; k < 3; k++) check("R5 R3 R4 mode3 sequential read", int'(rq[k]), refMem[16'h0105 + k]);
    mode3 = 0;

    wq = '{8'h99}; wrArr(16'h0105, 0);
    rdStat(1); check("R9 no latch no busy", int'(rq[0]), 8'hB4);
    rdArr(16'h0105, 1); check("R9 no latch keeps data", int'(rq[0]), 8'h11);

    // R7 page wrap: 34 bytes from offset 30
    op(8'h06);
    wq.delete();
    for (int k = 0; k < 34; k++) wq.push_back(8'(k * 7 + 1));
    wrArr(16'h041E, 0); modelWrite(16'h041E);
    tick(WR + 100);
    rdArr(16'h0400, 32);
    for (int k = 0; k < 32; k++) check("R7 page wrap content", int'(rq[k]), refMem[16'h0400 + k]);

    // R8 boundary rules
    op(8'h06); wq = '{8'h3C}; wrArr(16'h0200, 0); modelWrite(16'h0200); tick(WR + 100);
    op(8'h06); wq = '{8'h5A}; wrArr(16'h0200, 3);
    rdStat(1); check("R8 partial byte not committed", int'(rq[0]), 8'hB6);
    wq.delete(); wrArr(16'h0200, 0);
    rdStat(1); check("R8 no data byte not committed", int'(rq[0]), 8'hB6);
    rdArr(16'h0200, 1); check("R8 data unchanged", int'(rq[0]), 8'h3C);

    // R5 wrap from top address, R4 upper bits ignored
    op(8'h06); wq = '{8'hE1}; wrArr(16'h07FF, 0); modelWrite(16'h07FF); tick(WR + 100);
    op(8'h06); wq = '{8'hE2}; wrArr(16'h0000, 0); modelWrite(16'h0000); tick(WR + 100);
    rdArr(16'hFFFF, 2);
    check("R5 top byte", int'(rq[0]), 8'hE1);
    check("R5 wrap to zero", int'(rq[1]), 8'hE2);

    // R9 locked page
    lockEn = 1;
    op(8'h06); wq = '{8'h77}; wrArr(16'h0110, 0);
    rdStat(1); check("R9 locked page refused", int'(rq[0]), 8'hB6);
    lockEn = 0; op(8'h04);

    // R9 refused while busy
    op(8'h06); wq = '{8'h01}; wrArr(16'h0300, 0); modelWrite(16'h0300);
    wq = '{8'h02}; wrArr(16'h0300, 0);
    tick(WR + 100);
    rdArr(16'h0300, 1); check("R9 write during busy refused", int'(rq[0]), refMem[16'h0300]);

    // R12 status write
    op(8'h06); wrStat(8'h8C, 0);
    check("R12 strobe count", stbCnt, 1);
    check("R12 strobe byte", int'(stbByte), 8'h8C);
    rdStat(1); check("R12 busy after status write", int'(rq[0]), 8'hB7);
    tick(WR + 100);
    stLocked = 1; op(8'h06); wrStat(8'h55, 0);
    check("R12 locked status refused", stbCnt, 1);
    stLocked = 0; wrStat(8'h55, 1);
    check("R12 off-boundary status refused", stbCnt, 1);
    rdStat(1); check("R12 no busy after refusals", int'(rq[0]), 8'hB6);

    finishRun();
  end
endmodule